// File: doc/BRIEF.md
# Dual-Processor Interrupt Controller Register Front End

This block is the register-facing side of an interrupt controller shared by two processors. It accepts single-cycle bus accesses described by a byte address and an access size. From these it works out which byte lanes are touched and decides whether the access is legal. It then serves a small register map: one configuration word, one acknowledge word per processor and one end-of-interrupt word per processor. The configuration word holds, for each processor, a bit that selects hardware or software vector handshaking and a bit that selects 4-byte or 8-byte vector table entries.

An acknowledge read returns the processor's pending vector number merged into its vector table base. The vector is shifted left so that the entry size shows in the number of trailing zeros. An acknowledge read in software vector mode raises a one-cycle pulse for the arbitration logic. An end-of-interrupt write raises a one-cycle pulse in either mode. The access size has no effect on either pulse. The priority arbiter, the priority stack and the interrupt source inputs live elsewhere. The pending vector and the table base arrive on plain input ports.

Top module: `irqRegIf`

## Requirements
- R1: After reset, the configuration bits, the read data, the error flag and all pulses are zero.
- R2: Configuration word (word 0, byte address 0x00): processor 0 hardware-vector bit at bit 0, processor 0 entry-size bit at bit 5, processor 1 hardware-vector bit at bit 8, processor 1 entry-size bit at bit 13. A write changes only the bytes its lanes cover. Every other bit reads as zero. The configuration bits also appear on `hwVecEn` and `vecEntry8`.
- R3: `busSize` is 0 for a byte, 1 for a halfword and 2 for a word. A byte access may start at any offset within the word. A halfword may start at offset 0, 1 or 2. A word must start at offset 0. Size 3, a halfword at offset 3 and a word at a nonzero offset are illegal. Byte lane k carries data bits 8k+7..8k.
- R4: An illegal access, or an access to a word other than 0, 4, 5, 6 or 7, raises `busErr` for one cycle. It returns zero read data, changes no state and raises no pulse.
- R5: The acknowledge word of processor p sits at word 4+p (byte address 0x10 or 0x14). It reads as the table base with its low VEC_W+3 bits cleared, OR the pending vector shifted left by 2 (entry-size bit 0) or by 3 (entry-size bit 1).
- R6: A legal read of any size of processor p's acknowledge word pulses `ackPulse[p]` for one cycle when p's hardware-vector bit is 0. It raises no pulse when that bit is 1. The mode used is the one in force before the access.
- R7: A legal write of any size to processor p's end-of-interrupt word (word 6+p, byte address 0x18 or 0x1C) pulses `eoiPulse[p]` for one cycle in either mode. A read of that word returns zero. A write to an acknowledge word has no effect.
- R8: Read data appears on the cycle after the access. Bytes outside the accessed lanes read as zero, and a write returns zero. A single access raises at most one of the pulse and error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access present this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address |
| busSize | input | 2 | Access size code |
| busWData | input | 32 | Lane-aligned write data |
| busRData | output | 32 | Lane-aligned read data, one cycle later |
| busErr | output | 1 | One-cycle error response |
| pendVec0 | input | VEC_W | Pending vector, processor 0 |
| pendVec1 | input | VEC_W | Pending vector, processor 1 |
| tableBase0 | input | 32 | Vector table base, processor 0 |
| tableBase1 | input | 32 | Vector table base, processor 1 |
| ackPulse | output | 2 | Acknowledge side effect per processor |
| eoiPulse | output | 2 | End-of-interrupt side effect per processor |
| hwVecEn | output | 2 | Hardware-vector mode per processor |
| vecEntry8 | output | 2 | 8-byte entry selection per processor |

## Verification
A configuration bit in the wrong state shows at the ports on the next cycle. It appears directly on `hwVecEn` or `vecEntry8`, and it also moves the trailing zeros of every later acknowledge read or suppresses its pulse. A lane or legality decode error shows on the cycle after the faulty access, as wrong read bytes, a missing or spurious `busErr`, or a pulse on the wrong processor. Sweeping every address and size under several configurations exposes each of these within one access.

// File: rtl/irqRegIf_pkg.sv
package irqRegIf_pkg;
  localparam int NPROC = 2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int CFG_WORD  = 0;
  localparam int ACK_WORD0 = 4;
  localparam int EOI_WORD0 = 6;

  localparam int HV_POS0 = 0;
  localparam int ES_POS0 = 5;
  localparam int HV_POS1 = 8;
  localparam int ES_POS1 = 13;

  localparam logic [31:0] CFG_MASK = (32'd1 << HV_POS0) | (32'd1 << ES_POS0) |
                                     (32'd1 << HV_POS1) | (32'd1 << ES_POS1);

  typedef struct packed {
    logic [3:0]       laneEn;
    logic             cfgWr;
    logic             cfgRd;
    logic [NPROC-1:0] ackRd;
    logic [NPROC-1:0] eoiWr;
    logic             errHit;
  } ctlStrobe_t;
endpackage

// File: rtl/irqRegIf_ctl.sv
module irqRegIf_ctl
  import irqRegIf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ctlStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]       offset;
  logic [IDX_W-1:0] wordIdx;
  logic [3:0]       lanePat;
  logic             sizeOk;
  logic             mapped;
  logic             accOk;

  assign offset  = busAddr[1:0];
  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    case (busSize)
      SZ_BYTE: begin lanePat = 4'b0001; sizeOk = 1'b1;              end
      SZ_HALF: begin lanePat = 4'b0011; sizeOk = (offset != 2'd3);  end
      SZ_WORD: begin lanePat = 4'b1111; sizeOk = (offset == 2'd0);  end
      default: begin lanePat = 4'b0000; sizeOk = 1'b0;              end
    endcase
  end

  always_comb begin
    mapped = (wordIdx == IDX_W'(CFG_WORD));
    for (int p = 0; p < NPROC; p++) begin
      mapped = mapped | (wordIdx == IDX_W'(ACK_WORD0 + p))
                      | (wordIdx == IDX_W'(EOI_WORD0 + p));
    end
    accOk = busValid & sizeOk & mapped;
  end

  always_comb begin
    strb        = '0;
    strb.errHit = busValid & ~(sizeOk & mapped);
    strb.laneEn = accOk ? (lanePat << offset) : 4'b0000;
    strb.cfgWr  = accOk &  busWrite & (wordIdx == IDX_W'(CFG_WORD));
    strb.cfgRd  = accOk & ~busWrite & (wordIdx == IDX_W'(CFG_WORD));
    for (int p = 0; p < NPROC; p++) begin
      strb.ackRd[p] = accOk & ~busWrite & (wordIdx == IDX_W'(ACK_WORD0 + p));
      strb.eoiWr[p] = accOk &  busWrite & (wordIdx == IDX_W'(EOI_WORD0 + p));
    end
  end
endmodule

// File: rtl/irqRegIf_dp.sv
module irqRegIf_dp
  import irqRegIf_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  strb,
  input  logic [31:0]                 busWData,
  input  logic [NPROC-1:0][VEC_W-1:0] pendVec,
  input  logic [NPROC-1:0][31:0]      tableBase,
  output logic [31:0]                 busRData,
  output logic                        busErr,
  output logic [NPROC-1:0]            ackPulse,
  output logic [NPROC-1:0]            eoiPulse,
  output logic [NPROC-1:0]            hwVecEn,
  output logic [NPROC-1:0]            vecEntry8
);
  localparam logic [31:0] BASE_MASK = ~((32'd1 << (VEC_W + 3)) - 32'd1);

  logic [31:0]            cfgQ;
  logic [31:0]            cfgNext;
  logic [31:0]            laneMask;
  logic [31:0]            rdWord;
  logic [NPROC-1:0][31:0] ackVal;

  assign hwVecEn   = {cfgQ[HV_POS1], cfgQ[HV_POS0]};
  assign vecEntry8 = {cfgQ[ES_POS1], cfgQ[ES_POS0]};

  for (genvar p = 0; p < NPROC; p++) begin : g_ack
    logic [31:0] vecExt;
    assign vecExt    = 32'(pendVec[p]);
    assign ackVal[p] = (tableBase[p] & BASE_MASK) |
                       (vecEntry8[p] ? (vecExt << 3) : (vecExt << 2));
  end

  always_comb begin
    cfgNext = cfgQ;
    if (strb.cfgWr) begin
      for (int b = 0; b < 4; b++) begin
        if (strb.laneEn[b]) cfgNext[b*8 +: 8] = busWData[b*8 +: 8];
      end
    end
    cfgNext = cfgNext & CFG_MASK;
  end

  always_comb begin
    for (int b = 0; b < 4; b++) laneMask[b*8 +: 8] = {8{strb.laneEn[b]}};
    rdWord = '0;
    if (strb.cfgRd) rdWord = cfgQ;
    for (int p = 0; p < NPROC; p++) begin
      if (strb.ackRd[p]) rdWord = ackVal[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      busRData <= '0;
      busErr   <= 1'b0;
      ackPulse <= '0;
      eoiPulse <= '0;
    end else begin
      cfgQ     <= cfgNext;
      busRData <= rdWord & laneMask;
      busErr   <= strb.errHit;
      ackPulse <= strb.ackRd & ~hwVecEn;
      eoiPulse <= strb.eoiWr;
    end
  end
endmodule

// File: rtl/irqRegIf.sv
module irqRegIf
  import irqRegIf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VEC_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  output logic              busErr,
  input  logic [VEC_W-1:0]  pendVec0,
  input  logic [VEC_W-1:0]  pendVec1,
  input  logic [31:0]       tableBase0,
  input  logic [31:0]       tableBase1,
  output logic [1:0]        ackPulse,
  output logic [1:0]        eoiPulse,
  output logic [1:0]        hwVecEn,
  output logic [1:0]        vecEntry8
);
  ctlStrobe_t strb;

  irqRegIf_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .strb     (strb)
  );

  irqRegIf_dp #(.VEC_W(VEC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWData  (busWData),
    .pendVec   ({pendVec1, pendVec0}),
    .tableBase ({tableBase1, tableBase0}),
    .busRData  (busRData),
    .busErr    (busErr),
    .ackPulse  (ackPulse),
    .eoiPulse  (eoiPulse),
    .hwVecEn   (hwVecEn),
    .vecEntry8 (vecEntry8)
  );
endmodule

// File: rtl/irqRegIf_chk.sv
module irqRegIf_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [31:0] busRData,
  input logic        busErr,
  input logic [1:0]  ackPulse,
  input logic [1:0]  eoiPulse,
  input logic [1:0]  hwVecEn,
  input logic [1:0]  vecEntry8
);
  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRData == 32'd0 && ackPulse == 2'b00 && eoiPulse == 2'b00));

  // R6
  ack_hw_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse != 2'b00) |-> ((ackPulse & $past(hwVecEn)) == 2'b00));

  // R6
  ack_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse != 2'b00) |-> $past(busValid && !busWrite));

  // R7
  eoi_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiPulse != 2'b00) |-> $past(busValid && busWrite));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |=> $stable({hwVecEn, vecEntry8}));

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackPulse, eoiPulse, busErr}));
endmodule

bind irqRegIf irqRegIf_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busRData  (busRData),
  .busErr    (busErr),
  .ackPulse  (ackPulse),
  .eoiPulse  (eoiPulse),
  .hwVecEn   (hwVecEn),
  .vecEntry8 (vecEntry8)
);

// File: tb/irqRegIf_bench.sv
`timescale 1ns/1ps
module irqRegIf_bench;
  localparam int ADDR_W = 8;
  localparam int VEC_W  = 9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [1:0]        busSize = '0;
  logic [31:0]       busWData = '0;
  logic [31:0]       busRData;
  logic              busErr;
  logic [VEC_W-1:0]  pendVec0 = '0;
  logic [VEC_W-1:0]  pendVec1 = '0;
  logic [31:0]       tableBase0 = '0;
  logic [31:0]       tableBase1 = '0;
  logic [1:0]        ackPulse;
  logic [1:0]        eoiPulse;
  logic [1:0]        hwVecEn;
  logic [1:0]        vecEntry8;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mCfg = '0;
  logic [31:0] lcg  = 32'h1234_5678;

  always #2.5 clk = ~clk;

  irqRegIf #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_irqRegIf (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWData(busWData),
    .busRData(busRData), .busErr(busErr), .pendVec0(pendVec0),
    .pendVec1(pendVec1), .tableBase0(tableBase0), .tableBase1(tableBase1),
    .ackPulse(ackPulse), .eoiPulse(eoiPulse), .hwVecEn(hwVecEn),
    .vecEntry8(vecEntry8)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ackModel(int p);
    logic [31:0] base, vec;
    int sh;
    base = (p == 0) ? tableBase0 : tableBase1;
    vec  = (p == 0) ? 32'(pendVec0) : 32'(pendVec1);
    sh   = mCfg[(p == 0) ? 5 : 13] ? 3 : 2;
    return (base & ~((32'd1 << (VEC_W + 3)) - 32'd1)) | (vec << sh);
  endfunction

  task automatic doAccess(bit wr, int addr, int sz, logic [31:0] wd);
    int off, word, nBytes;
    bit legal, mapped, err;
    logic [31:0] mask, full, expR;
    logic [1:0] expAck, expEoi;
    off  = addr % 4;
    word = addr / 4;
    nBytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    legal  = (sz == 0) || (sz == 1 && off != 3) || (sz == 2 && off == 0);
    mapped = (word == 0) || (word >= 4 && word <= 7);
    err    = !(legal && mapped);
    mask = '0;
    if (!err) for (int b = off; b < off + nBytes; b++) mask[b*8 +: 8] = 8'hFF;
    full = (word == 0) ? mCfg : (word == 4) ? ackModel(0) : (word == 5) ? ackModel(1) : 32'd0;
    expR = (!err && !wr) ? (full & mask) : 32'd0;
    expAck[0] = !err && !wr && word == 4 && !mCfg[0];
    expAck[1] = !err && !wr && word == 5 && !mCfg[8];
    expEoi[0] = !err && wr && word == 6;
    expEoi[1] = !err && wr && word == 7;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = ADDR_W'(addr);
    busSize = 2'(sz); busWData = wd;
    @(negedge clk);
    busValid = 1'b0;
    if (!err && wr && word == 0) mCfg = ((mCfg & ~mask) | (wd & mask)) & 32'h0000_2121;
    chk("R8 rdata", 64'(busRData), 64'(expR));
    chk("R4 err", 64'(busErr), 64'(err));
    chk("R6 ackPulse", 64'(ackPulse), 64'(expAck));
    chk("R7 eoiPulse", 64'(eoiPulse), 64'(expEoi));
    chk("R2 cfgOut", 64'({hwVecEn, vecEntry8}),
        64'({mCfg[8], mCfg[0], mCfg[13], mCfg[5]}));
    @(negedge clk);
    chk("R8 oneCycle", 64'({ackPulse, eoiPulse, busErr}), 64'(0));
  endtask

  function automatic logic [31:0] nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cfgPats [4];
    cfgPats[0] = 32'h0000_0000;
    cfgPats[1] = 32'hFFFF_FFFF;
    cfgPats[2] = 32'h0000_0101;
    cfgPats[3] = 32'h0000_2020;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", 64'({busRData, busErr, ackPulse, eoiPulse, hwVecEn, vecEntry8}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 afterRelease", 64'({busRData, busErr, ackPulse, eoiPulse, hwVecEn, vecEntry8}), 64'(0));

    // R3 R5 R6: read sweep over every address and size per configuration
    for (int c = 0; c < 4; c++) begin
      doAccess(1'b1, 0, 2, cfgPats[c]);
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        for (int s = 0; s < 4; s++) begin
          pendVec0   = VEC_W'(a * 7 + s * 131 + c);
          pendVec1   = VEC_W'(511 - a * 3 - s);
          tableBase0 = nextRand();
          tableBase1 = nextRand();
          doAccess(1'b0, a, s, 32'd0);
        end
      end
    end

    // R5 all vector values in both entry sizes
    for (int c = 0; c < 2; c++) begin
      doAccess(1'b1, 0, 2, c ? 32'h0000_2020 : 32'h0);
      for (int v = 0; v < (1 << VEC_W); v++) begin
        pendVec0 = VEC_W'(v); pendVec1 = VEC_W'(~v);
        doAccess(1'b0, 16 + 4 * (v % 2), 2, 32'd0);
      end
    end

    // R2 R7: write sweep, partial and misaligned lanes, acknowledge writes ignored
    for (int rep = 0; rep < 6; rep++) begin
      for (int a = 0; a < 32; a++) begin
        for (int s = 0; s < 4; s++) begin
          doAccess(1'b1, a, s, nextRand());
          doAccess(1'b0, 0, 2, 32'd0);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule